// File: doc/BRIEF.md
# Interrupt Polarity Normalizer Bank

This block sits between a bank of wakeup interrupt pins and a downstream interrupt controller that only senses active-high levels and rising edges. Each pin has its own 3-bit trigger mode and an enable bit, both held in a small 32-bit register file. The block resynchronizes every pin and detects transitions. It then produces one normalized output line per pin. An active-low level comes out as an active-high level. A falling edge, a rising edge or either transition (in the dual mode) comes out as a single-cycle high pulse.

Software sets a pin's trigger mode first and then its enable bit. Edge detection always works on the raw, synchronized pin value and never on a polarity-adjusted copy. Because of this, changing a pin's mode while the pin holds still cannot create a false event. A pin that is disabled, or set to an undefined mode, keeps its output low.

Top module: `irq_polarity_bank`

## Requirements
- R1: After reset every output is low, every enable bit reads 0 and every configuration word reads 3'b100 (level active-high).
- R2: In mode 3'b100 an enabled pin's output equals the pin level, three clock edges after the pin changes.
- R3: In mode 3'b000 an enabled pin's output is the inverse of the pin level, with the same three-edge latency.
- R4: In mode 3'b110 a low-to-high pin transition produces exactly one output cycle high, three edges later. A high-to-low transition produces nothing.
- R5: In mode 3'b010 a high-to-low pin transition produces exactly one output cycle high, three edges later. A low-to-high transition produces nothing.
- R6: In mode 3'b111 every pin transition, in either direction, produces a one-cycle output pulse.
- R7: A pin whose enable bit is 0 drives its output low. Transitions that happened while it was disabled produce no pulse once it is enabled.
- R8: The undefined mode codes 3'b001, 3'b011 and 3'b101 keep the output low whatever the pin does.
- R9: Writing a new mode while the pin is steady produces no output pulse.
- R10: The enable bit of pin p is bit p%32 of the word at byte address 0x10+4*(p/32). The mode of pin p is bits [2:0] of the word at 0x110+4*p. A read returns data on `bus_rdata` one clock after the request.
- R11: Configuration bits [31:3], enable bits of pins at or beyond NUM_PINS, and every unmapped address read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read request |
| pin_in | input | NUM_PINS (168) | Raw asynchronous interrupt pins |
| irq_out | output | NUM_PINS (168) | Normalized active-high / rising-edge interrupts |

## Verification
The bench goes after the mode-change corner case. It switches rising, falling and dual modes while a pin is held high or low. A design that detected edges after the polarity inversion would show a spurious pulse here. It also toggles a disabled pin and then enables it, which catches an edge history that stops updating while the pin is disabled. It checks the first, a middle and the last pin. This catches off-by-one errors in the word/bit split of the enable bank. It also catches any missing mask on enable bits beyond the last pin, which would read back as ones. The undefined mode codes get pin activity of their own, so a design that let them decay to a level mode would drive the output.

// File: rtl/irq_nrm_pkg.sv
package irq_nrm_pkg;

    localparam int EN_BASE  = 'h10;
    localparam int CFG_BASE = 'h110;

    typedef enum logic [2:0] {
        TRIG_LVL_LOW  = 3'b000,
        TRIG_FALL     = 3'b010,
        TRIG_LVL_HIGH = 3'b100,
        TRIG_RISE     = 3'b110,
        TRIG_BOTH     = 3'b111
    } trig_e;

    typedef struct packed {
        logic meta;
        logic cur;
        logic prev;
    } lane_hist_t;

    function automatic logic is_defined(input logic [2:0] code);
        return (code == TRIG_LVL_LOW) || (code == TRIG_FALL) ||
               (code == TRIG_LVL_HIGH) || (code == TRIG_RISE) ||
               (code == TRIG_BOTH);
    endfunction

    function automatic logic lane_next(input logic [2:0] code,
                                       input logic cur, input logic prev);
        logic r;
        case (code)
            TRIG_LVL_LOW:  r = ~cur;
            TRIG_LVL_HIGH: r = cur;
            TRIG_RISE:     r = cur & ~prev;
            TRIG_FALL:     r = ~cur & prev;
            TRIG_BOTH:     r = cur ^ prev;
            default:       r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_nrm_regfile.sv
module irq_nrm_regfile
    import irq_nrm_pkg::*;
#(
    parameter int NUM_PINS = 168,
    parameter int ADDR_W   = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_en,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic [NUM_PINS-1:0]      en_o,
    output logic [NUM_PINS-1:0][2:0] cfg_o
);
    localparam int EN_WORDS = (NUM_PINS + 31) / 32;

    logic [NUM_PINS-1:0]      en_q;
    logic [NUM_PINS-1:0][2:0] cfg_q;
    logic [EN_WORDS*32-1:0]   en_pad;
    logic [31:0]              rd_n;
    logic [31:0]              rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            for (int p = 0; p < NUM_PINS; p++) cfg_q[p] <= TRIG_LVL_HIGH;
        end else if (bus_en && bus_we) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (bus_addr == ADDR_W'(EN_BASE + 4 * (p / 32)))
                    en_q[p] <= bus_wdata[p % 32];
                if (bus_addr == ADDR_W'(CFG_BASE + 4 * p))
                    cfg_q[p] <= bus_wdata[2:0];
            end
        end
    end

    assign en_pad = (EN_WORDS*32)'(en_q);

    always_comb begin
        rd_n = '0;
        for (int w = 0; w < EN_WORDS; w++)
            if (bus_addr == ADDR_W'(EN_BASE + 4 * w)) rd_n = en_pad[w*32 +: 32];
        for (int p = 0; p < NUM_PINS; p++)
            if (bus_addr == ADDR_W'(CFG_BASE + 4 * p)) rd_n = {29'b0, cfg_q[p]};
    end

    always_ff @(posedge clk) begin
        if (rst)                     rd_q <= '0;
        else if (bus_en && !bus_we)  rd_q <= rd_n;
    end

    assign bus_rdata = rd_q;
    assign en_o      = en_q;
    assign cfg_o     = cfg_q;

    // R11: a configuration read never returns bits above the mode field
    p_cfg_upper_zero_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_en && !bus_we) && $past(bus_addr) >= ADDR_W'(CFG_BASE))
        |-> (bus_rdata[31:3] == 29'b0));

endmodule

// File: rtl/irq_nrm_lane.sv
module irq_nrm_lane
    import irq_nrm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin,
    input  logic       en,
    input  logic [2:0] cfg,
    output logic       irq
);
    lane_hist_t h_q;
    logic       irq_q;
    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q   <= '0;
            irq_q <= 1'b0;
            age_q <= '0;
        end else begin
            h_q.meta <= pin;
            h_q.cur  <= h_q.meta;
            h_q.prev <= h_q.cur;
            irq_q    <= en & lane_next(cfg, h_q.cur, h_q.prev);
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
        end
    end

    assign irq = irq_q;

    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> !irq);

    p_reserved_silent_r8: assert property (@(posedge clk) disable iff (rst)
        !is_defined(cfg) |=> !irq);

    p_rise_single_r4: assert property (@(posedge clk) disable iff (rst)
        (irq && cfg == TRIG_RISE && $past(cfg) == TRIG_RISE) |=> !irq);

    p_fall_single_r5: assert property (@(posedge clk) disable iff (rst)
        (irq && cfg == TRIG_FALL && $past(cfg) == TRIG_FALL) |=> !irq);

    p_level_high_r2: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3 && $past(en) && $past(cfg) == TRIG_LVL_HIGH &&
         pin == $past(pin) && $past(pin) == $past(pin, 2) &&
         $past(pin, 2) == $past(pin, 3)) |-> (irq == $past(pin, 3)));

    p_level_low_r3: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3 && $past(en) && $past(cfg) == TRIG_LVL_LOW &&
         pin == $past(pin) && $past(pin) == $past(pin, 2) &&
         $past(pin, 2) == $past(pin, 3)) |-> (irq == !$past(pin, 3)));

endmodule

// File: rtl/irq_polarity_bank.sv
module irq_polarity_bank
    import irq_nrm_pkg::*;
#(
    parameter int NUM_PINS = 168,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] irq_out
);
    logic [NUM_PINS-1:0]      en_w;
    logic [NUM_PINS-1:0][2:0] cfg_w;

    irq_nrm_regfile #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .en_o      (en_w),
        .cfg_o     (cfg_w)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_lane
        irq_nrm_lane u_lane (
            .clk (clk),
            .rst (rst),
            .pin (pin_in[g]),
            .en  (en_w[g]),
            .cfg (cfg_w[g]),
            .irq (irq_out[g])
        );
    end

endmodule

// File: tb/tb_irq_polarity_bank.sv
module tb_irq_polarity_bank;
    localparam int NP = 168;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] irq_out;

    int errors = 0;
    int checks = 0;
    logic [31:0] en_sh [6];

    always #2.5 clk = ~clk;

    irq_polarity_bank dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        tick(1);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_cfg(input int p, input logic [31:0] v);
        wr(12'(32'h110 + 4 * p), v);
    endtask

    task automatic set_en(input int p, input logic v);
        en_sh[p / 32][p % 32] = v;
        wr(12'(32'h10 + 4 * (p / 32)), en_sh[p / 32]);
    endtask

    // output must stay low for n cycles: one check
    task automatic quiet(input int p, input int n, input string req);
        logic seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            seen |= irq_out[p];
        end
        chk(req, {31'b0, seen}, 32'd0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 outputs", {31'b0, |irq_out}, 32'd0);
        rd(12'h010, d); chk("R1 enable word0", d, 32'd0);
        rd(12'h024, d); chk("R1 enable word5", d, 32'd0);
        rd(12'h110, d); chk("R1 cfg pin0", d, 32'd4);
        rd(12'h3AC, d); chk("R1 cfg pin167", d, 32'd4);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        set_cfg(37, 32'hFFFF_FFF6);
        rd(12'h110 + 12'd148, d); chk("R10/R11 cfg pin37 masked", d, 32'd6);
        wr(12'h024, 32'hFFFF_FFFF);
        rd(12'h024, d); chk("R11 enable word5 beyond last pin", d, 32'h0000_00FF);
        wr(12'h024, 32'h0);
        rd(12'h000, d); chk("R11 unmapped low", d, 32'd0);
        rd(12'h3B0, d); chk("R11 unmapped past last cfg", d, 32'd0);
        set_en(37, 1'b1);
        rd(12'h014, d); chk("R10 pin37 enable word1 bit5", d, 32'h0000_0020);
        set_en(37, 1'b0);
        set_cfg(37, 32'd4);
    endtask

    task automatic t_level_high;
        set_en(0, 1'b1);
        pin_in[0] = 1'b1; tick(2);
        chk("R2 latency not early", {31'b0, irq_out[0]}, 32'd0);
        tick(1); chk("R2 high follows", {31'b0, irq_out[0]}, 32'd1);
        tick(3); chk("R2 high held", {31'b0, irq_out[0]}, 32'd1);
        pin_in[0] = 1'b0; tick(3);
        chk("R2 low follows", {31'b0, irq_out[0]}, 32'd0);
    endtask

    task automatic t_level_low;
        set_cfg(37, 32'd0); set_en(37, 1'b1);
        tick(1); chk("R3 low pin asserts", {31'b0, irq_out[37]}, 32'd1);
        pin_in[37] = 1'b1; tick(3);
        chk("R3 high pin deasserts", {31'b0, irq_out[37]}, 32'd0);
        pin_in[37] = 1'b0; tick(3);
        chk("R3 re-asserts", {31'b0, irq_out[37]}, 32'd1);
        set_en(37, 1'b0);
    endtask

    task automatic t_rise;
        set_cfg(167, 32'd6); set_en(167, 1'b1);
        pin_in[167] = 1'b1; tick(3);
        chk("R4 rising pulse", {31'b0, irq_out[167]}, 32'd1);
        quiet(167, 4, "R4 single cycle");
        pin_in[167] = 1'b0;
        quiet(167, 6, "R4 falling ignored");
    endtask

    task automatic t_fall;
        set_cfg(1, 32'd2); set_en(1, 1'b1);
        pin_in[1] = 1'b1;
        quiet(1, 6, "R5 rising ignored");
        pin_in[1] = 1'b0; tick(3);
        chk("R5 falling pulse", {31'b0, irq_out[1]}, 32'd1);
        quiet(1, 4, "R5 single cycle");
    endtask

    task automatic t_both;
        set_cfg(2, 32'd7); set_en(2, 1'b1);
        pin_in[2] = 1'b1; tick(3);
        chk("R6 pulse on rise", {31'b0, irq_out[2]}, 32'd1);
        quiet(2, 3, "R6 rise single cycle");
        pin_in[2] = 1'b0; tick(3);
        chk("R6 pulse on fall", {31'b0, irq_out[2]}, 32'd1);
        quiet(2, 3, "R6 fall single cycle");
    endtask

    task automatic t_disabled;
        set_cfg(3, 32'd6);
        pin_in[3] = 1'b1;
        quiet(3, 6, "R7 disabled stays low");
        set_en(3, 1'b1);
        quiet(3, 6, "R7 stale edge not reported");
        pin_in[3] = 1'b0; tick(4);
        pin_in[3] = 1'b1; tick(3);
        chk("R7 enabled edge reported", {31'b0, irq_out[3]}, 32'd1);
        set_en(3, 1'b0); pin_in[3] = 1'b0;
        set_cfg(0, 32'd4); tick(4);
        chk("R7 disabled level pin low", {31'b0, irq_out[3]}, 32'd0);
    endtask

    task automatic t_reserved;
        set_en(4, 1'b1);
        for (int k = 0; k < 3; k++) begin
            logic seen = 1'b0;
            set_cfg(4, 32'(2 * k + 1));
            for (int i = 0; i < 12; i++) begin
                if (i % 3 == 0) pin_in[4] = ~pin_in[4];
                tick(1);
                seen |= irq_out[4];
            end
            chk("R8 reserved code silent", {31'b0, seen}, 32'd0);
        end
        set_en(4, 1'b0);
    endtask

    task automatic t_phantom;
        set_en(5, 1'b1);
        set_cfg(5, 32'd2); quiet(5, 5, "R9 low pin to falling");
        set_cfg(5, 32'd6); quiet(5, 5, "R9 low pin to rising");
        pin_in[5] = 1'b1; tick(3);
        chk("R9 real rise still seen", {31'b0, irq_out[5]}, 32'd1);
        tick(3);
        set_cfg(5, 32'd2); quiet(5, 5, "R9 high pin to falling");
        set_cfg(5, 32'd7); quiet(5, 5, "R9 high pin to dual");
        set_cfg(5, 32'd6); quiet(5, 5, "R9 high pin back to rising");
        set_en(5, 1'b0);
    endtask

    initial begin
        for (int w = 0; w < 6; w++) en_sh[w] = '0;
        tick(4);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_regmap();
        t_level_high();
        t_level_low();
        t_rise();
        t_fall();
        t_both();
        t_disabled();
        t_reserved();
        t_phantom();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule